// File: doc/BRIEF.md
# Parallel Bus Target Transfer Controller

This block is the target end of the byte-wide information transfer phases on an 8-bit parallel bus with one odd-parity line. A controller starts a phase with a single-cycle pulse that carries the phase code and the number of bytes. The block then holds the phase lines for the whole burst and runs one request/acknowledge handshake per byte. All of its delays are counted in clock cycles.

When the phase code's direction bit is set, bytes come from a local valid/ready stream and go out on the bus. When the direction bit is clear, bytes are captured from the bus and offered on a second valid/ready stream.

Back-pressure rules:
- The bus side never waits on the outbound stream once a byte is on the lines. The block only takes a new byte, with `tx_ready`, after the previous handshake has fully closed.
- On the inbound side, a captured byte stays on `rx_data` with `rx_valid` high until `rx_ready` is seen. No further request is raised while that byte is unaccepted.

The acknowledge input passes through a two-flop synchronizer, so every decision on it lags the pin by two cycles.

Top module: `bus_tgt_xfer`

## Requirements
- R1: Every completed request/acknowledge handshake moves exactly one byte and its parity bit, and a phase makes exactly `start_count` handshakes.
- R2: While a phase is active, `bus_bsy` is high and `bus_sel` is low. When idle, `bus_bsy`, `bus_req`, `bus_db_oe`, `bus_cd`, `bus_msg` and `bus_io` are all low.
- R3: The phase lines are driven for at least `SETTLE_CYC` cycles before the first request of a phase is raised.
- R4: `{bus_cd, bus_msg, bus_io}` equals `start_phase[2:0]` (bit 2 = C/D, bit 1 = MSG, bit 0 = I/O) and stays unchanged from the accepted start until `done`, which comes after the last acknowledge is negated.
- R5: With I/O high, data flows from target to initiator and `bus_db_oe` is high for the whole phase. With I/O low, `bus_db_oe` stays low and bytes are received.
- R6: When sending, the data and parity lines hold a new byte for at least `SKEW_CYC` cycles before the request rises. They stay unchanged while the request is high. The request drops once the synchronized acknowledge is seen high.
- R7: A request is never raised until the acknowledge of the previous handshake has been seen low after the request fell.
- R8: The transmitted parity bit gives the nine lines an odd number of ones.
- R9: When receiving, a byte whose nine lines carry an even number of ones sets `par_err`. The flag stays set until the next accepted start clears it.
- R10: When receiving, the byte is latched when the synchronized acknowledge is seen high. It is offered on `rx_data`/`rx_valid` only after the acknowledge is negated, and it is held until `rx_ready`. The next request waits for that acceptance.
- R11: `done` is a one-cycle pulse after the final acknowledge negation, and `bus_bsy` is low in the following cycle.
- R12: A start pulse is ignored while a phase is active or when `start_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Phase start pulse |
| start_phase | input | 3 | Phase code {C/D, MSG, I/O} |
| start_count | input | CNT_W | Bytes in the phase |
| done | output | 1 | Phase finished pulse |
| par_err | output | 1 | Sticky receive parity error |
| tx_valid | input | 1 | Outbound byte available |
| tx_data | input | 8 | Outbound byte |
| tx_ready | output | 1 | Outbound byte taken |
| rx_valid | output | 1 | Inbound byte available |
| rx_data | output | 8 | Inbound byte |
| rx_ready | input | 1 | Inbound byte taken |
| bus_bsy | output | 1 | Busy line |
| bus_sel | output | 1 | Select line, held low |
| bus_cd | output | 1 | Control/data phase line |
| bus_msg | output | 1 | Message phase line |
| bus_io | output | 1 | Direction line |
| bus_req | output | 1 | Request line |
| bus_ack | input | 1 | Acknowledge line (asynchronous) |
| bus_db_out | output | 8 | Data lines driven |
| bus_dbp_out | output | 1 | Parity line driven |
| bus_db_oe | output | 1 | Data and parity output enable |
| bus_db_in | input | 8 | Data lines sampled |
| bus_dbp_in | input | 1 | Parity line sampled |

## Verification
The hardest case to reach is a receive burst in which the local consumer stalls while the initiator is ready at once. This is where a premature next request would show. The stimulus withholds `rx_ready` on random cycles while the initiator model answers each request after zero to two cycles. Receive bursts also corrupt the parity of one chosen byte, which shows that the flag is sticky and is cleared only by a later start. A second start is pulsed in the middle of an active phase to show that it changes nothing on the bus.

// File: rtl/bus_tgt_pkg.sv
package bus_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_FETCH,
    ST_SKEW,
    ST_REQ,
    ST_RELEASE,
    ST_PUSH,
    ST_DONE
  } xfer_st_e;

  // bit that makes eight data bits plus itself carry an odd number of ones
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/bus_tgt_sync.sv
module bus_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bus_tgt_timer.sv
module bus_tgt_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  // a running window of `limit` cycles ends in its last cycle
  assign expired = run && (cnt >= limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expired) cnt <= '0;
    else                      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bus_tgt_txpath.sv
module bus_tgt_txpath
  import bus_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] tx_data,
  output logic [7:0] db,
  output logic       dbp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db  <= '0;
      dbp <= 1'b1;
    end else if (load) begin
      db  <= tx_data;
      dbp <= odd_par(tx_data);
    end
  end
endmodule

// File: rtl/bus_tgt_rxpath.sv
module bus_tgt_rxpath
  import bus_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       push,
  input  logic       clear_err,
  input  logic [7:0] db_in,
  input  logic       dbp_in,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       par_err
);
  // the initiator holds the lines well before the synchronized acknowledge
  // is seen, so the capture samples settled data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_data <= '0;
    else if (capture) rx_data <= db_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 par_err <= 1'b0;
    else if (capture && dbp_in != odd_par(db_in)) par_err <= 1'b1;
    else if (clear_err)                         par_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rx_valid <= 1'b0;
    else if (push)                rx_valid <= 1'b1;
    else if (rx_valid && rx_ready) rx_valid <= 1'b0;
  end
endmodule

// File: rtl/bus_tgt_xfer.sv
module bus_tgt_xfer
  import bus_tgt_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SKEW_CYC   = 3,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       start_phase,
  input  logic [CNT_W-1:0] start_count,
  output logic             done,
  output logic             par_err,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             bus_bsy,
  output logic             bus_sel,
  output logic             bus_cd,
  output logic             bus_msg,
  output logic             bus_io,
  output logic             bus_req,
  input  logic             bus_ack,
  output logic [7:0]       bus_db_out,
  output logic             bus_dbp_out,
  output logic             bus_db_oe,
  input  logic [7:0]       bus_db_in,
  input  logic             bus_dbp_in
);
  localparam int MAX_WIN = (SETTLE_CYC > SKEW_CYC) ? SETTLE_CYC : SKEW_CYC;
  localparam int TMR_W   = $clog2(MAX_WIN + 1);
  localparam logic [TMR_W-1:0] SETTLE_LIM = TMR_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0] SKEW_LIM   = TMR_W'(SKEW_CYC);

  xfer_st_e         st, st_nx;
  logic [2:0]       ph_q;
  logic [CNT_W-1:0] rem;
  logic             ack_s;
  logic             tmr_run, tmr_exp;
  logic [TMR_W-1:0] tmr_lim;
  logic             start_ok, dir_out, last_byte;
  logic             byte_end_tx, byte_end_rx;

  assign dir_out   = ph_q[0];
  assign last_byte = (rem == CNT_W'(1));
  assign start_ok  = start && (st == ST_IDLE) && (start_count != '0);

  bus_tgt_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
  );

  assign tmr_run = (st == ST_SETTLE) || (st == ST_SKEW);
  assign tmr_lim = (st == ST_SETTLE) ? SETTLE_LIM : SKEW_LIM;

  bus_tgt_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_lim), .expired(tmr_exp)
  );

  // phase sequencing
  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (start_ok) st_nx = ST_SETTLE;
      ST_SETTLE:  if (tmr_exp) st_nx = dir_out ? ST_FETCH : ST_REQ;
      ST_FETCH:   if (tx_valid) st_nx = ST_SKEW;
      ST_SKEW:    if (tmr_exp) st_nx = ST_REQ;
      ST_REQ:     if (ack_s) st_nx = ST_RELEASE;
      ST_RELEASE: if (!ack_s) begin
                    if (!dir_out)       st_nx = ST_PUSH;
                    else if (last_byte) st_nx = ST_DONE;
                    else                st_nx = ST_FETCH;
                  end
      ST_PUSH:    if (rx_valid && rx_ready) st_nx = last_byte ? ST_DONE : ST_REQ;
      ST_DONE:    st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  assign byte_end_tx = (st == ST_RELEASE) && !ack_s && dir_out;
  assign byte_end_rx = (st == ST_PUSH) && rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ph_q <= '0;
      rem  <= '0;
    end else begin
      st <= st_nx;
      if (start_ok) begin
        ph_q <= start_phase;
        rem  <= start_count;
      end else if (st == ST_DONE) begin
        ph_q <= '0;
      end else if (byte_end_tx || byte_end_rx) begin
        rem <= rem - CNT_W'(1);
      end
    end
  end

  // outbound data
  assign tx_ready = (st == ST_FETCH);

  bus_tgt_txpath u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_valid && tx_ready), .tx_data(tx_data),
    .db(bus_db_out), .dbp(bus_dbp_out)
  );

  // inbound data
  bus_tgt_rxpath u_rx (
    .clk(clk), .rst_n(rst_n),
    .capture((st == ST_REQ) && ack_s && !dir_out),
    .push((st == ST_RELEASE) && !ack_s && !dir_out),
    .clear_err(start_ok),
    .db_in(bus_db_in), .dbp_in(bus_dbp_in), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .par_err(par_err)
  );

  // bus side
  assign bus_bsy   = (st != ST_IDLE);
  assign bus_sel   = 1'b0;
  assign bus_cd    = ph_q[2];
  assign bus_msg   = ph_q[1];
  assign bus_io    = ph_q[0];
  assign bus_req   = (st == ST_REQ);
  assign bus_db_oe = bus_bsy && dir_out;
  assign done      = (st == ST_DONE);
endmodule

// File: rtl/bus_tgt_xfer_chk.sv
module bus_tgt_xfer_chk #(
  parameter int SETTLE_CYC = 4,
  parameter int SKEW_CYC   = 3,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       start_phase,
  input logic [CNT_W-1:0] start_count,
  input logic             done,
  input logic             par_err,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             rx_ready,
  input logic             bus_bsy,
  input logic             bus_sel,
  input logic             bus_cd,
  input logic             bus_msg,
  input logic             bus_io,
  input logic             bus_req,
  input logic             bus_ack,
  input logic [7:0]       bus_db_out,
  input logic             bus_dbp_out,
  input logic             bus_db_oe,
  input logic [7:0]       bus_db_in,
  input logic             bus_dbp_in
);
  logic [15:0] since_busy, db_age;
  logic [7:0]  prev_db;
  logic        req_q, ack_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_busy <= '0;
      db_age     <= '0;
      prev_db    <= '0;
      req_q      <= 1'b0;
      ack_pend   <= 1'b0;
    end else begin
      since_busy <= !bus_bsy ? '0 : (since_busy == 16'hFFFF ? since_busy : since_busy + 16'd1);
      db_age     <= (bus_db_out != prev_db) ? '0 : (db_age == 16'hFFFF ? db_age : db_age + 16'd1);
      prev_db    <= bus_db_out;
      req_q      <= bus_req;
      if (req_q && !bus_req) ack_pend <= 1'b1;
      else if (!bus_ack)     ack_pend <= 1'b0;
    end
  end

  p_sel_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bsy |-> !bus_sel);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bsy |-> !bus_req && !bus_db_oe && !bus_cd && !bus_msg && !bus_io);
  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> since_busy >= 16'(SETTLE_CYC));
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bsy && $past(bus_bsy) |-> $stable({bus_cd, bus_msg, bus_io}));
  p_oe_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bsy |-> bus_db_oe == bus_io);
  // data unchanged for SKEW_CYC cycles up to and including the request edge
  p_skew_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && bus_io |-> db_age >= 16'(SKEW_CYC - 1));
  p_db_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && $past(bus_req) && bus_io |-> $stable({bus_db_out, bus_dbp_out}));
  p_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !ack_pend);
  p_tx_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_io |-> $countones({bus_db_out, bus_dbp_out}) % 2 == 1);
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  p_rx_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !bus_req);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !bus_bsy);
endmodule

bind bus_tgt_xfer bus_tgt_xfer_chk #(
  .SETTLE_CYC(SETTLE_CYC), .SKEW_CYC(SKEW_CYC), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/bus_tgt_xfer_test.sv
`timescale 1ns/1ps
module bus_tgt_xfer_test;
  localparam int SETTLE = 4;
  localparam int SKEW   = 3;
  localparam int CW     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 0;
  logic [2:0]    start_phase = 0;
  logic [CW-1:0] start_count = 0;
  logic          done, par_err;
  logic          tx_valid = 0;
  logic [7:0]    tx_data = 0;
  logic          tx_ready;
  logic          rx_valid;
  logic [7:0]    rx_data;
  logic          rx_ready = 0;
  logic          bus_bsy, bus_sel, bus_cd, bus_msg, bus_io, bus_req;
  logic          bus_ack = 0;
  logic [7:0]    bus_db_out;
  logic          bus_dbp_out, bus_db_oe;
  logic [7:0]    bus_db_in = 0;
  logic          bus_dbp_in = 0;

  bus_tgt_xfer #(.SETTLE_CYC(SETTLE), .SKEW_CYC(SKEW), .CNT_W(CW)) uut (.*);

  int checks = 0;
  int fails  = 0;

  // handshakes observed at the clock edge, read back at the next falling edge
  logic       tx_fire = 0, rx_fire = 0;
  logic [7:0] rx_fire_data = 0;
  always @(posedge clk) begin
    tx_fire      <= tx_valid && tx_ready;
    rx_fire      <= rx_valid && rx_ready;
    rx_fire_data <= rx_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic want_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2 == 0);
  endfunction

  logic [7:0] pat [32];

  task automatic run_phase(input logic [2:0] ph, input int n, input int bad,
                           input bit slow_rx, input bit poke);
    int k = 0, ti = 0, ri = 0, ist = 0, dly = 0, settle = -1, rises = 0;
    int ph_err = 0, sel_err = 0, oe_err = 0, tx_err = 0, ptx_err = 0, hold_err = 0;
    int rx_err = 0, stall_err = 0, ack_err = 0, skew_min = 1000, db_age = 0;
    int done_k = -1;
    bit got_done = 0, prev_req = 0, err_at_start = 0;
    logic [7:0] cap = 0, prev_db;
    for (int i = 0; i < n; i++) pat[i] = 8'($urandom);
    @(negedge clk);
    start = 1; start_phase = ph; start_count = CW'(n);
    @(negedge clk);
    start = 0;
    prev_db = bus_db_out;
    err_at_start = par_err;
    for (int c = 0; c < 4000 && !got_done; c++) begin
      if (bus_bsy) begin
        if ({bus_cd, bus_msg, bus_io} != ph) ph_err++;
        if (bus_sel) sel_err++;
        if (bus_db_oe != ph[0]) oe_err++;
      end
      if (bus_db_out != prev_db) db_age = 0; else db_age++;
      prev_db = bus_db_out;
      if (bus_req && !prev_req) begin
        rises++;
        if (settle < 0) settle = c;
        if (ph[0] && db_age < skew_min) skew_min = db_age;
        if (bus_ack) ack_err++;
      end
      prev_req = bus_req;
      // initiator model
      case (ist)
        0: if (bus_req) begin
             if (ph[0]) begin
               cap = bus_db_out;
               if (cap !== pat[k]) tx_err++;
               if (bus_dbp_out !== want_par(cap)) ptx_err++;
             end else begin
               bus_db_in  = pat[k];
               bus_dbp_in = want_par(pat[k]) ^ (k == bad);
             end
             dly = $urandom % 3; ist = 1;
           end
        1: begin
             if (ph[0] && bus_db_out !== cap) hold_err++;
             if (dly == 0) begin bus_ack = 1; ist = 2; end else dly--;
           end
        2: begin
             if (bus_req && ph[0] && bus_db_out !== cap) hold_err++;
             if (!bus_req) begin dly = $urandom % 3; ist = 3; end
           end
        default: if (dly == 0) begin bus_ack = 0; k++; ist = 0; end else dly--;
      endcase
      // local stream producer
      if (tx_fire) ti++;
      tx_valid = ph[0] && (ti < n) && ($urandom % 4 != 0);
      tx_data  = (ti < n) ? pat[ti] : 8'h00;
      // local stream consumer
      if (rx_fire) begin
        if (ri >= n || rx_fire_data !== pat[ri]) rx_err++;
        ri++;
      end
      if (rx_valid && !rx_ready && bus_req) stall_err++;
      rx_ready = slow_rx ? ($urandom % 3 == 0) : 1'b1;
      // a second start in mid-phase must change nothing (R12)
      if (poke && c == 5) begin
        start = 1; start_phase = ~ph; start_count = CW'(3);
      end else start = 0;
      if (done) begin
        got_done = 1; done_k = k;
        chk(!bus_ack, "R11 ack low at done", bus_ack, 0);
      end
      @(negedge clk);
    end
    start = 0;
    chk(got_done, "R11 done reached", got_done, 1);
    chk(done_k == n, "R11 done after final ack negation", done_k, n);
    chk(!bus_bsy && !done, "R11 busy released after done", bus_bsy, 0);
    chk(err_at_start == 0, "R9 flag cleared by start", err_at_start, 0);
    chk(ph_err == 0, "R4 phase lines held", ph_err, 0);
    chk(sel_err == 0, "R2 select low while busy", sel_err, 0);
    chk(oe_err == 0, "R5 output enable follows direction", oe_err, 0);
    chk(settle >= SETTLE, "R3 settle before first request", settle, SETTLE);
    chk(rises == n, "R1 one handshake per byte", rises, n);
    chk(ack_err == 0, "R7 request only after ack low", ack_err, 0);
    if (ph[0]) begin
      chk(tx_err == 0, "R1 bytes on bus", tx_err, 0);
      chk(ptx_err == 0, "R8 odd parity sent", ptx_err, 0);
      chk(skew_min >= SKEW, "R6 data ahead of request", skew_min, SKEW);
      chk(hold_err == 0, "R6 data held during request", hold_err, 0);
      chk(ti == n, "R5 outbound bytes taken", ti, n);
    end else begin
      chk(ri == n && rx_err == 0, "R10 inbound bytes in order", rx_err, 0);
      chk(stall_err == 0, "R10 no request while byte unaccepted", stall_err, 0);
      chk(par_err == (bad >= 0 && bad < n), "R9 parity error flag",
          par_err, (bad >= 0 && bad < n));
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(!bus_bsy && !bus_req && !bus_db_oe && !done && !tx_ready && !rx_valid,
        "R2 quiet in reset", bus_bsy, 0);
    rst_n = 1;
    @(negedge clk);
    chk({bus_cd, bus_msg, bus_io} == 3'b000 && !bus_sel, "R2 idle phase lines", bus_cd, 0);
    // zero count is ignored
    start = 1; start_phase = 3'b101; start_count = '0;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(!bus_bsy && !done && !bus_io, "R12 zero count ignored", bus_bsy, 0);
    // directed corners
    run_phase(3'b001, 4, -1, 0, 1);
    run_phase(3'b100, 5, 2, 1, 0);
    run_phase(3'b110, 1, -1, 0, 0);
    run_phase(3'b011, 1, -1, 0, 0);
    run_phase(3'b000, 3, 0, 1, 1);
    // constrained random bursts
    for (int it = 0; it < 10; it++) begin
      int n;
      n = 1 + ($urandom % 12);
      run_phase(3'($urandom), n, ($urandom % 3 == 0) ? int'($urandom % n) : -1,
                bit'($urandom % 2), bit'($urandom % 2));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule